// File: doc/BRIEF.md
# Host-Readable Word Mailbox Queue

This block is a first-in first-out queue of 32-bit words that an on-chip producer fills and a host processor drains through a small word-addressed register window. The producer presents a word with a one-cycle push strobe. The host can pop the oldest word, look at it without removing it, read a status word (full flag, empty flag, fill level), and read or write a configuration word that holds an interrupt enable and a has-data pending flag.

Reading the pop window while the queue holds nothing does not stall. It returns the all-ones marker and leaves the queue untouched. The pending flag follows the non-empty state of the queue. A level-sensitive interrupt line is raised while the flag is set and the host has enabled it. Storage is a shift-down queue: slot 0 is always the head, and every pop moves the remaining words one slot toward it. Read data is combinational and valid in the same cycle as the read strobe. A pop or push takes effect at the next rising clock edge.

Top module: `mail_fifo`

## Requirements
- R1: After reset the status word reads 0x4000_0000, the configuration word reads 0, the interrupt output is low, and a peek returns 0xFFFF_FFFF.
- R2: Pushed words are returned in push order by reads at any of the byte offsets 0x80, 0x84, 0x88 and 0x8C. Each such read removes one word.
- R3: A read of the pop window while the queue is empty returns 0xFFFF_FFFF and leaves the fill level at 0.
- R4: A read at offset 0x90 returns the head word and does not remove it.
- R5: The status word at offset 0x98 has bit 31 set only when the fill level equals DEPTH, bit 30 set only when the level is 0, and bits 7:0 equal to the fill level. All other bits are 0.
- R6: A push while the queue is full is dropped, unless a pop is accepted in the same cycle, in which case the push is stored behind the remaining words.
- R7: A write at offset 0x9C updates only bit 0 (interrupt enable) of the configuration word. Bit 4 and all other bits ignore the written value.
- R8: Configuration bit 4 (has-data pending) reads 1 exactly when the queue is non-empty. The interrupt output is high exactly when bit 4 and bit 0 are both 1.
- R9: A read at an offset outside 0x80–0x90, 0x98 and 0x9C returns 0 and removes nothing. A write to any offset other than 0x9C changes no state.
- R10: A slot vacated by a pop reads back as 0xFFFF_FFFF, so a peek after the queue drains returns the marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | ADDR_W | Byte offset into the register window |
| reg_rd | input | 1 | Read strobe; a pop takes effect at the clock edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high; 0 otherwise |
| prod_push | input | 1 | Producer push strobe |
| prod_data | input | 32 | Producer word |
| host_irq | output | 1 | Level interrupt toward the host |

## Verification
The bench builds the block with DEPTH set to 4, so that a few pushes reach the full flag. At that depth the bench can test the dropped push into a full queue and the pop-plus-push in the same cycle at full. It also sees the level field at its top value and confirms that the vacated tail slot refills with the marker. ADDR_W stays at 10, which keeps the unmapped offsets at both ends of the window within reach.

// File: rtl/mail_pkg.sv
package mail_pkg;

  localparam logic [31:0] MAIL_MARK = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_POP,
    SEL_PEEK,
    SEL_STAT,
    SEL_CFG
  } mail_sel_e;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_PEND_BIT = 4;
  localparam int STAT_FULL    = 31;
  localparam int STAT_EMPTY   = 30;

endpackage

// File: rtl/mail_decode.sv
module mail_decode
  import mail_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output mail_sel_e         sel,
  output logic              pop_req,
  output logic              cfg_wr
);

  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] IDX_POP0 = IW'(32);
  localparam logic [IW-1:0] IDX_PEEK = IW'(36);
  localparam logic [IW-1:0] IDX_STAT = IW'(38);
  localparam logic [IW-1:0] IDX_CFG  = IW'(39);

  logic [IW-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (idx[IW-1:2] == IDX_POP0[IW-1:2]) sel = SEL_POP;
    else if (idx == IDX_PEEK)             sel = SEL_PEEK;
    else if (idx == IDX_STAT)             sel = SEL_STAT;
    else if (idx == IDX_CFG)              sel = SEL_CFG;
  end

  assign pop_req = rd && (sel == SEL_POP);
  assign cfg_wr  = wr && (sel == SEL_CFG);

endmodule

// File: rtl/mail_queue.sv
module mail_queue
  import mail_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nx,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  ent_q  [DEPTH];
  logic [W-1:0]  ent_nx [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          pop_eff;
  logic          push_ok;
  logic [CW-1:0] wr_idx;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign pop_eff = pop && !empty;
  assign push_ok = push && (!full || pop_eff);
  assign wr_idx  = pop_eff ? cnt_q - CW'(1) : cnt_q;

  always_comb begin
    count_nx = cnt_q;
    if (push_ok && !pop_eff)      count_nx = cnt_q + CW'(1);
    else if (pop_eff && !push_ok) count_nx = cnt_q - CW'(1);
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic [W-1:0] shifted;
    if (gi < DEPTH - 1) begin : g_mid
      assign shifted = ent_q[gi+1];
    end else begin : g_tail
      assign shifted = MAIL_MARK;
    end

    always_comb begin
      ent_nx[gi] = pop_eff ? shifted : ent_q[gi];
      if (push_ok && (wr_idx == CW'(gi))) ent_nx[gi] = push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ent_q[gi] <= MAIL_MARK;
      else if (pop_eff || push_ok) ent_q[gi] <= ent_nx[gi];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= count_nx;
  end

  assign head  = ent_q[0];
  assign count = cnt_q;

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == CW'(DEPTH)));

  a_r3_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (cnt_q == '0));

  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  a_r10_tail_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < CW'(DEPTH)) |-> (ent_q[DEPTH-1] == MAIL_MARK));

endmodule

// File: rtl/mail_ctrl.sv
module mail_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic event_any,
  input  logic cfg_wr,
  input  logic en_wdata,
  input  logic nonempty_nx,
  output logic irq_en,
  output logic pend,
  output logic irq
);

  logic en_q, en_nx;
  logic pend_q, pend_nx;

  always_comb begin
    en_nx   = cfg_wr ? en_wdata : en_q;
    pend_nx = event_any ? nonempty_nx : pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_nx;
      pend_q <= pend_nx;
    end
  end

  assign irq_en = en_q;
  assign pend   = pend_q;
  assign irq    = en_q && pend_q;

  a_r7_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(en_q));

endmodule

// File: rtl/mail_fifo.sv
module mail_fifo
  import mail_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              prod_push,
  input  logic [31:0]       prod_data,
  output logic              host_irq
);

  localparam int CW = $clog2(DEPTH + 1);

  logic          rst_m, rst_s;
  mail_sel_e     sel;
  logic          pop_req, cfg_wr;
  logic [31:0]   head;
  logic [CW-1:0] count, count_nx;
  logic          full, empty;
  logic          irq_en, pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  mail_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (reg_addr),
    .rd      (reg_rd),
    .wr      (reg_wr),
    .sel     (sel),
    .pop_req (pop_req),
    .cfg_wr  (cfg_wr)
  );

  mail_queue #(.DEPTH(DEPTH), .W(32), .CW(CW)) u_q (
    .clk       (clk),
    .rst_n     (rst_s),
    .pop       (pop_req),
    .push      (prod_push),
    .push_data (prod_data),
    .head      (head),
    .count     (count),
    .count_nx  (count_nx),
    .full      (full),
    .empty     (empty)
  );

  mail_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_s),
    .event_any   (reg_rd || reg_wr || prod_push),
    .cfg_wr      (cfg_wr),
    .en_wdata    (reg_wdata[CFG_EN_BIT]),
    .nonempty_nx (count_nx != '0),
    .irq_en      (irq_en),
    .pend        (pend),
    .irq         (host_irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (sel)
        SEL_POP:  reg_rdata = empty ? MAIL_MARK : head;
        SEL_PEEK: reg_rdata = head;
        SEL_STAT: begin
          reg_rdata[STAT_FULL]  = full;
          reg_rdata[STAT_EMPTY] = empty;
          reg_rdata[7:0]        = 8'(count);
        end
        SEL_CFG: begin
          reg_rdata[CFG_EN_BIT]   = irq_en;
          reg_rdata[CFG_PEND_BIT] = pend;
        end
        default: reg_rdata = '0;
      endcase
    end
  end

  a_r8_pend_tracks: assert property (@(posedge clk) disable iff (!rst_s)
    pend == !empty);

  a_r8_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_s)
    host_irq |-> !empty);

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_s)
    !(full && empty));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_rd && sel == SEL_NONE) |-> (reg_rdata == '0));

endmodule

// File: tb/mail_fifo_test.sv
module mail_fifo_test;

  localparam int DEPTH  = 4;
  localparam int ADDR_W = 10;
  localparam logic [31:0] MARK = 32'hFFFF_FFFF;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] reg_addr;
  logic              reg_rd, reg_wr;
  logic [31:0]       reg_wdata, reg_rdata;
  logic              prod_push;
  logic [31:0]       prod_data;
  logic              host_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  mail_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .prod_push(prod_push), .prod_data(prod_data), .host_irq(host_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    prod_push = 1'b1; prod_data = d;
    @(negedge clk);
    prod_push = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    rchk("R1 status", 10'h98, 32'h4000_0000);
    rchk("R1 config", 10'h9C, 32'h0);
    chk("R1 irq", {31'b0, host_irq}, 32'h0);
    rchk("R1 peek", 10'h90, MARK);
  endtask

  task automatic t_empty_pop;
    rchk("R3 empty pop", 10'h80, MARK);
    rchk("R3 level", 10'h98, 32'h4000_0000);
  endtask

  task automatic t_order;
    push(32'hA1); push(32'hB2); push(32'hC3);
    rchk("R5 level3", 10'h98, 32'h0000_0003);
    rchk("R4 peek", 10'h90, 32'hA1);
    rchk("R4 peek again", 10'h90, 32'hA1);
    rchk("R4 level kept", 10'h98, 32'h0000_0003);
    rchk("R2 pop 0x84", 10'h84, 32'hA1);
    rchk("R2 pop 0x88", 10'h88, 32'hB2);
    rchk("R2 pop 0x8C", 10'h8C, 32'hC3);
    rchk("R5 empty", 10'h98, 32'h4000_0000);
  endtask

  task automatic t_full;
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) push(32'h100 + i);
    rchk("R5 full", 10'h98, 32'h8000_0004);
    push(32'hDEAD);
    rchk("R6 drop level", 10'h98, 32'h8000_0004);
    @(negedge clk);
    reg_addr = 10'h80; reg_rd = 1'b1; prod_push = 1'b1; prod_data = 32'h5A5A;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; prod_push = 1'b0;
    chk("R6 pop at full", d, 32'h100);
    rchk("R6 still full", 10'h98, 32'h8000_0004);
    for (int i = 1; i < DEPTH; i++) rchk("R6 drain", 10'h80, 32'h100 + i);
    rchk("R6 joined word", 10'h80, 32'h5A5A);
    rchk("R10 peek marker", 10'h90, MARK);
    rchk("R10 pop marker", 10'h80, MARK);
  endtask

  task automatic t_irq;
    push(32'h77);
    rchk("R8 pend only", 10'h9C, 32'h10);
    chk("R8 irq off", {31'b0, host_irq}, 32'h0);
    wr(10'h9C, 32'hFFFF_FFFF);
    rchk("R7 cfg en", 10'h9C, 32'h11);
    chk("R8 irq on", {31'b0, host_irq}, 32'h1);
    rchk("R8 pop", 10'h80, 32'h77);
    rchk("R8 pend clear", 10'h9C, 32'h01);
    chk("R8 irq drop", {31'b0, host_irq}, 32'h0);
    wr(10'h9C, 32'h0000_0010);
    rchk("R7 pend not written", 10'h9C, 32'h0);
    chk("R7 irq low", {31'b0, host_irq}, 32'h0);
  endtask

  task automatic t_unmapped;
    push(32'hCAFE);
    rchk("R9 sender slot", 10'h94, 32'h0);
    rchk("R9 low", 10'h00, 32'h0);
    rchk("R9 top", 10'h3FC, 32'h0);
    rchk("R9 level", 10'h98, 32'h0000_0001);
    wr(10'h80, 32'h1234);
    wr(10'h98, 32'hFFFF_FFFF);
    rchk("R9 wr ignored level", 10'h98, 32'h0000_0001);
    rchk("R9 wr ignored head", 10'h90, 32'hCAFE);
    rchk("R9 cfg untouched", 10'h9C, 32'h10);
    rchk("R2 final pop", 10'h80, 32'hCAFE);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_rd = 1'b0; reg_wr = 1'b0;
    reg_wdata = '0; prod_push = 1'b0; prod_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_empty_pop();
    t_order();
    t_full();
    t_irq();
    t_unmapped();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule